// File: doc/BRIEF.md
# Conversion Result Byte Port

This block keeps the most recent converter result and hands it to a host over a byte-wide bus. A result is a 12-bit count plus a sign flag and an over-range flag. The conversion sequencer loads it with a one-cycle strobe. The host reads it back as two lanes: a low lane with the eight least significant count bits, and a high lane with the remaining count bits and the two flags.

There are two ways to read. In direct mode, the host uses an active-low chip enable and one active-low enable per lane, and each lane's output enable follows those pins. In handshake mode, the block sends the low byte and then the high byte by itself. Each byte stays on its lane until the receiver acknowledges it with a one-clock `send_i` pulse. A single rising edge on `mode_i` starts one such transfer of the held result. Holding `mode_i` high starts a transfer after every new load.

While a transfer is in progress, the held result is frozen. A load that arrives then is parked and applied once the transfer ends, so both bytes of a transfer always come from the same conversion.

Top module: `adc_byte_port`

## Requirements
- R1: After reset both lane output enables and `hs_valid_o` are low.
- R2: The low lane carries count bits [7:0]. The high lane carries count bits [11:8] in bits [3:0], the sign flag in bit 4, the over-range flag in bit 5 and zeros in bits [7:6]. `result_i` packs count in [11:0], sign in [12] and over-range in [13].
- R3: Outside a transfer, a lane's output enable is high in the cycle after a clock edge at which `ce_n_i` and that lane's enable (`lben_n_i` or `hben_n_i`) were both low, and low otherwise.
- R4: Outside a transfer, the held result changes only at a clock edge where `load_i` is high. The new value is on the lanes right after that edge.
- R5: With `mode_i` low, loads never start a transfer and `hs_valid_o` stays low.
- R6: A rising edge of `mode_i` seen while idle starts a transfer at that clock edge. `hs_valid_o` rises, only the low lane is enabled, and it carries the low byte.
- R7: Each byte stays on its lane until an edge with `send_i` high. The acknowledge of the low byte moves to the high byte with only the high lane enabled. The acknowledge of the high byte ends the transfer and returns the lanes to direct control.
- R8: With `mode_i` held high, a load accepted at edge k starts a transfer at edge k+1.
- R9: A load during a transfer leaves both transferred bytes unchanged. It is applied at the first edge after the transfer ends. With `mode_i` high, a new transfer of it starts one edge later.
- R10: During a transfer the chip and lane enables have no effect on the lane output enables.
- R11: A rising edge of `mode_i` during a transfer is ignored and starts no further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | One-cycle result load strobe from the sequencer |
| result_i | input | 14 | Result: over-range [13], sign [12], count [11:0] |
| mode_i | input | 1 | Low: direct reads; rising edge or held high: handshake transfers |
| ce_n_i | input | 1 | Active-low chip enable for direct reads |
| lben_n_i | input | 1 | Active-low low-lane enable |
| hben_n_i | input | 1 | Active-low high-lane enable |
| send_i | input | 1 | Receiver acknowledge of the byte on the lanes |
| lo_data_o | output | 8 | Low lane data |
| lo_oe_o | output | 1 | Low lane drive enable (low means high impedance) |
| hi_data_o | output | 8 | High lane data |
| hi_oe_o | output | 1 | High lane drive enable (low means high impedance) |
| hs_valid_o | output | 1 | A handshake byte is on the lanes awaiting acknowledge |

## Verification
Results arrive on a fixed schedule:
- A load, a direct-enable change and each acknowledge take effect on the lanes one edge after they are sampled.
- A mode rising edge starts a transfer at the edge that samples it.
- A load with mode held high starts its transfer one edge after the load.
- A deferred load is applied one edge after the transfer ends and is transferred one edge after that.

The bench drives inputs on the falling edge and advances one rising edge at a time. It checks at the next falling edge, and around each of these points it checks both the cycle before the change is due and the cycle it is due.

// File: rtl/adc_byte_pkg.sv
package adc_byte_pkg;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_LO   = 2'd1,
    XF_HI   = 2'd2
  } xfer_state_e;

  localparam int LANE_LO   = 0;
  localparam int LANE_HI   = 1;
  localparam int NUM_LANES = 2;

endpackage

// File: rtl/abp_result_store.sv
module abp_result_store #(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             busy_i,
  output logic [RES_W-1:0] latch_o,
  output logic             upd_o
);

  logic [RES_W-1:0] latch_q, latch_d;
  logic [RES_W-1:0] pend_q;
  logic             pend_v_q, pend_v_d;
  logic             upd_q;
  logic             take_new, take_pend, defer, latch_en;

  always_comb begin
    take_new  = load_i & ~busy_i;
    take_pend = pend_v_q & ~busy_i & ~load_i;
    defer     = load_i & busy_i;
    latch_en  = take_new | take_pend;
    latch_d   = take_new ? result_i : pend_q;
    pend_v_d  = pend_v_q;
    if (defer)         pend_v_d = 1'b1;
    else if (latch_en) pend_v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      upd_q    <= 1'b0;
    end else begin
      if (latch_en) latch_q <= latch_d;
      if (defer)    pend_q  <= result_i;
      pend_v_q <= pend_v_d;
      upd_q    <= latch_en;
    end
  end

  assign latch_o = latch_q;
  assign upd_o   = upd_q;

  // R9: the held result is frozen while a transfer runs
  assert_frozen_in_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(latch_q));

  // R9: a parked load survives until the transfer ends
  assert_defer_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && busy_i) |=> pend_v_q);

  // R4: no change of the held result without a load or a parked load
  assert_load_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !pend_v_q) |=> $stable(latch_q));

endmodule

// File: rtl/abp_xfer_ctrl.sv
module abp_xfer_ctrl
  import adc_byte_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_i,
  input  logic                 upd_i,
  input  logic                 send_i,
  output logic                 busy_o,
  output logic [NUM_LANES-1:0] sel_o
);

  xfer_state_e state_q, state_d;
  logic        mode_q;
  logic        start;

  always_comb begin
    start   = (state_q == XF_IDLE) & mode_i & (~mode_q | upd_i);
    state_d = state_q;
    case (state_q)
      XF_IDLE: if (start)  state_d = XF_LO;
      XF_LO:   if (send_i) state_d = XF_HI;
      XF_HI:   if (send_i) state_d = XF_IDLE;
      default:             state_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_i;
    end
  end

  always_comb begin
    sel_o          = '0;
    sel_o[LANE_LO] = (state_q == XF_LO);
    sel_o[LANE_HI] = (state_q == XF_HI);
    busy_o         = (state_q != XF_IDLE);
  end

  // R7: a byte stays until acknowledged
  assert_hold_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XF_LO && !send_i) |=> state_q == XF_LO);

  // R7: acknowledge of the high byte ends the transfer
  assert_hi_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XF_HI && send_i) |=> state_q == XF_IDLE);

  // R8: fresh result with mode held starts a transfer
  assert_held_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XF_IDLE && upd_i && mode_i) |=> state_q == XF_LO);

  // R5: with mode low no transfer begins
  assert_direct_stay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XF_IDLE && !mode_i) |=> state_q == XF_IDLE);

endmodule

// File: rtl/abp_lane_drive.sv
module abp_lane_drive
  import adc_byte_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int LANE_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ce_n_i,
  input  logic [NUM_LANES-1:0]            ben_n_i,
  input  logic                            hs_active_i,
  input  logic [NUM_LANES-1:0]            hs_sel_i,
  input  logic [CNT_W+1:0]                latch_i,
  output logic [NUM_LANES-1:0][LANE_W-1:0] lane_data_o,
  output logic [NUM_LANES-1:0]            lane_oe_o
);

  localparam int HI_CNT_W = CNT_W - LANE_W;
  localparam int HI_RAW_W = HI_CNT_W + 2;
  localparam int HI_PAD_W = LANE_W - HI_RAW_W;

  logic [HI_RAW_W-1:0] hi_raw;

  assign hi_raw = {latch_i[CNT_W+1], latch_i[CNT_W], latch_i[CNT_W-1:LANE_W]};
  assign lane_data_o[LANE_LO] = latch_i[LANE_W-1:0];

  if (HI_PAD_W > 0) begin : g_hi_pad
    assign lane_data_o[LANE_HI] = {{HI_PAD_W{1'b0}}, hi_raw};
  end else begin : g_hi_nopad
    assign lane_data_o[LANE_HI] = hi_raw[LANE_W-1:0];
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic dir_q, dir_d;

    assign dir_d = ~ce_n_i & ~ben_n_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_q <= 1'b0;
      else        dir_q <= dir_d;
    end

    assign lane_oe_o[g] = hs_active_i ? hs_sel_i[g] : dir_q;

    // R3: a lane not selected by its enables stays undriven
    assert_dir_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n_i || ben_n_i[g]) |=> (hs_active_i || !lane_oe_o[g]));
  end

  // R10: exactly one lane driven during a transfer, whatever the enables
  assert_one_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hs_active_i |-> ($countones(lane_oe_o) == 1));

endmodule

// File: rtl/adc_byte_port.sv
module adc_byte_port
  import adc_byte_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CNT_W+1:0]  result_i,
  input  logic              mode_i,
  input  logic              ce_n_i,
  input  logic              lben_n_i,
  input  logic              hben_n_i,
  input  logic              send_i,
  output logic [LANE_W-1:0] lo_data_o,
  output logic              lo_oe_o,
  output logic [LANE_W-1:0] hi_data_o,
  output logic              hi_oe_o,
  output logic              hs_valid_o
);

  localparam int RES_W = CNT_W + 2;

  logic [RES_W-1:0]                latch;
  logic                            upd;
  logic                            busy;
  logic [NUM_LANES-1:0]            sel;
  logic [NUM_LANES-1:0]            ben_n;
  logic [NUM_LANES-1:0][LANE_W-1:0] lane_data;
  logic [NUM_LANES-1:0]            lane_oe;

  assign ben_n[LANE_LO] = lben_n_i;
  assign ben_n[LANE_HI] = hben_n_i;

  abp_result_store #(.RES_W(RES_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .result_i (result_i),
    .busy_i   (busy),
    .latch_o  (latch),
    .upd_o    (upd)
  );

  abp_xfer_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .upd_i  (upd),
    .send_i (send_i),
    .busy_o (busy),
    .sel_o  (sel)
  );

  abp_lane_drive #(.CNT_W(CNT_W), .LANE_W(LANE_W)) u_lanes (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n_i      (ce_n_i),
    .ben_n_i     (ben_n),
    .hs_active_i (busy),
    .hs_sel_i    (sel),
    .latch_i     (latch),
    .lane_data_o (lane_data),
    .lane_oe_o   (lane_oe)
  );

  assign lo_data_o  = lane_data[LANE_LO];
  assign hi_data_o  = lane_data[LANE_HI];
  assign lo_oe_o    = lane_oe[LANE_LO];
  assign hi_oe_o    = lane_oe[LANE_HI];
  assign hs_valid_o = busy;

  // R11: a mode edge during a transfer never doubles it
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel[LANE_HI] && send_i && !upd) |=> !busy);

endmodule

// File: tb/adc_byte_port_tb.sv
`timescale 1ns/1ps
module adc_byte_port_tb;

  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [13:0] result_i;
  logic        mode_i, ce_n_i, lben_n_i, hben_n_i, send_i;
  logic [7:0]  lo_data_o, hi_data_o;
  logic        lo_oe_o, hi_oe_o, hs_valid_o;

  int checks = 0;
  int failures = 0;

  adc_byte_port u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .result_i(result_i),
    .mode_i(mode_i), .ce_n_i(ce_n_i), .lben_n_i(lben_n_i), .hben_n_i(hben_n_i),
    .send_i(send_i), .lo_data_o(lo_data_o), .lo_oe_o(lo_oe_o),
    .hi_data_o(hi_data_o), .hi_oe_o(hi_oe_o), .hs_valid_o(hs_valid_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [13:0] v);
    result_i = v;
    load_i = 1'b1;
    step();
    load_i = 1'b0;
  endtask

  task automatic ack();
    send_i = 1'b1;
    step();
    send_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 lo_oe after reset", {7'd0, lo_oe_o}, 8'd0);
    chk("R1 hi_oe after reset", {7'd0, hi_oe_o}, 8'd0);
    chk("R1 hs_valid after reset", {7'd0, hs_valid_o}, 8'd0);
  endtask

  task automatic t_direct();
    load(14'h2A5C);
    ce_n_i = 1'b0; lben_n_i = 1'b0;
    step();
    chk("R3 lo_oe with ce+lben", {7'd0, lo_oe_o}, 8'd1);
    chk("R3 hi_oe stays off", {7'd0, hi_oe_o}, 8'd0);
    chk("R2 R4 low lane data", lo_data_o, 8'h5C);
    lben_n_i = 1'b1; hben_n_i = 1'b0;
    chk("R3 lo_oe before edge", {7'd0, lo_oe_o}, 8'd1);
    step();
    chk("R3 hi_oe with ce+hben", {7'd0, hi_oe_o}, 8'd1);
    chk("R3 lo_oe off", {7'd0, lo_oe_o}, 8'd0);
    chk("R2 high lane data", hi_data_o, 8'h2A);
    ce_n_i = 1'b1;
    step();
    chk("R3 hi_oe off without ce", {7'd0, hi_oe_o}, 8'd0);
    chk("R5 no transfer in direct", {7'd0, hs_valid_o}, 8'd0);
  endtask

  task automatic t_load_gate();
    result_i = 14'h1111;
    step();
    step();
    chk("R4 no load keeps low", lo_data_o, 8'h5C);
    load(14'h13F0);
    chk("R4 R2 low after load", lo_data_o, 8'hF0);
    chk("R2 high sign flag", hi_data_o, 8'h13);
  endtask

  task automatic t_mode_low();
    load(14'h0123);
    for (int i = 0; i < 3; i++) begin
      chk("R5 hs_valid stays low", {7'd0, hs_valid_o}, 8'd0);
      step();
    end
  endtask

  task automatic t_pulse();
    load(14'h2A5C);
    ce_n_i = 1'b0; lben_n_i = 1'b0; hben_n_i = 1'b1;
    step();
    mode_i = 1'b1;
    step();
    mode_i = 1'b0;
    chk("R6 hs_valid on rise", {7'd0, hs_valid_o}, 8'd1);
    chk("R6 low lane only", {6'd0, hi_oe_o, lo_oe_o}, 8'b01);
    chk("R6 low byte sent", lo_data_o, 8'h5C);
    step(); step();
    chk("R7 low byte held", {6'd0, hi_oe_o, lo_oe_o}, 8'b01);
    ack();
    chk("R7 R10 high lane only", {6'd0, hi_oe_o, lo_oe_o}, 8'b10);
    chk("R7 high byte sent", hi_data_o, 8'h2A);
    step();
    chk("R7 high byte held", {7'd0, hs_valid_o}, 8'd1);
    ack();
    chk("R7 transfer ended", {7'd0, hs_valid_o}, 8'd0);
    chk("R7 back to direct", {6'd0, hi_oe_o, lo_oe_o}, 8'b01);
    ce_n_i = 1'b1; lben_n_i = 1'b1;
    step();
  endtask

  task automatic t_held_and_defer();
    mode_i = 1'b1;
    step();
    chk("R6 held rise starts", {7'd0, hs_valid_o}, 8'd1);
    ack(); ack();
    chk("R8 idle after first", {7'd0, hs_valid_o}, 8'd0);
    load(14'h07E1);
    chk("R8 not yet at k", {7'd0, hs_valid_o}, 8'd0);
    step();
    chk("R8 transfer at k+1", {7'd0, hs_valid_o}, 8'd1);
    chk("R8 low byte", lo_data_o, 8'hE1);
    load(14'h3FFF);
    chk("R9 low byte unchanged", lo_data_o, 8'hE1);
    ack();
    chk("R9 high byte same conv", hi_data_o, 8'h07);
    ack();
    chk("R9 idle at end", {7'd0, hs_valid_o}, 8'd0);
    step();
    chk("R9 parked load applied", lo_data_o, 8'hFF);
    chk("R9 not started yet", {7'd0, hs_valid_o}, 8'd0);
    step();
    chk("R9 parked transfer starts", {7'd0, hs_valid_o}, 8'd1);
    ack();
    chk("R9 parked high byte", hi_data_o, 8'h3F);
    ack();
    mode_i = 1'b0;
    step();
  endtask

  task automatic t_rise_ignored();
    mode_i = 1'b1;
    step();
    mode_i = 1'b0;
    step();
    mode_i = 1'b1;
    step();
    mode_i = 1'b0;
    ack();
    mode_i = 1'b1;
    step();
    mode_i = 1'b0;
    ack();
    for (int i = 0; i < 3; i++) begin
      chk("R11 no extra transfer", {7'd0, hs_valid_o}, 8'd0);
      step();
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; result_i = '0; mode_i = 1'b0;
    ce_n_i = 1'b1; lben_n_i = 1'b1; hben_n_i = 1'b1; send_i = 1'b0;
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_direct();
    t_load_gate();
    t_mode_low();
    t_pulse();
    t_held_and_defer();
    t_rise_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule